// File: doc/BRIEF.md
# Cascaded Secondary Interrupt Controller

This block collects up to 32 level-sensitive interrupt sources and presents them to a 32-input primary controller. Each source is qualified by an enable bit. A qualified source goes one of two ways. If its bit in the bypass register is clear, it is merged with every other such source onto one cascade line, which feeds primary input 31. If its bypass bit is set, it leaves on a dedicated output wired to the primary input with the same index. A typical bypass setting is 0xFFD00000, which routes sources 20 and 22 through 31 straight to the primary controller.

Software manages the enable mask through two write-only ports. One sets bits and the other clears them, so a single bit can change without a read-modify-write sequence. Software can read the masked pending state as a status word. Both interrupt outputs are registered and follow the sources with one clock of latency. The controller does no vectoring and no prioritisation.

Top module: `sic_cascade_ctrl`

## Requirements
- R1: After a synchronous reset, the enable mask and the bypass mask are both zero, `cascade_irq` is low and `bypass_irq` is all zero. A status read returns 0.
- R2: A write to address 1 (enable-set) sets each enable bit whose data bit is 1. All other enable bits keep their value.
- R3: A write to address 2 (enable-clear) clears each enable bit whose data bit is 1. All other enable bits keep their value.
- R4: A read of address 0 (status) returns the bitwise AND of the live `src_irq` levels and the enable mask. `bus_rdata` is valid on the clock edge after the one that samples `bus_rd`.
- R5: One clock after the sources change, `cascade_irq` is high exactly when at least one source is pending, enabled and not selected for bypass.
- R6: One clock after the sources change, `bypass_irq[i]` equals `src_irq[i]` AND enable bit i AND bypass bit i. A bypassed source never affects `cascade_irq`.
- R7: A read of address 1 or address 2 returns the current enable mask.
- R8: A write to address 3 loads the bypass mask with the whole data word. A read of address 3 returns the bypass mask.
- R9: A write to address 0 has no effect on the enable mask, the bypass mask or the outputs.
- R10: Sources are levels, not edges. When a source drops or its enable is cleared, its contribution to the outputs disappears one clock later and to status reads at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_irq | input | NSRC | Level interrupt sources, synchronous to clk |
| bus_addr | input | 2 | Register word address (0 status, 1 enable-set, 2 enable-clear, 3 bypass) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | NSRC | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | NSRC | Registered read data |
| cascade_irq | output | 1 | Merged non-bypassed interrupt, to primary input 31 |
| bypass_irq | output | NSRC | Per-source direct interrupts, to primary inputs of the same index |

## Verification
The assertions assume that `src_irq` is already synchronous to `clk`. They also assume that a write strobe is never given during reset, and that each access targets exactly one address. The bench meets these conditions by changing sources and bus signals only on the falling edge, and by starting bus traffic only after reset has been released. It holds each strobe for exactly one cycle. The vector table mixes bypassed and merged sources, disabled sources and sources that are not pending. This exercises every combination of the enable bit and the bypass bit.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int SIC_ADDR_W = 2;
  typedef enum logic [SIC_ADDR_W-1:0] {
    REG_STATUS = 2'd0,
    REG_EN_SET = 2'd1,
    REG_EN_CLR = 2'd2,
    REG_BYPASS = 2'd3
  } sic_reg_e;
endpackage

// File: rtl/sic_mask_regs.sv
module sic_mask_regs
  import sic_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [SIC_ADDR_W-1:0] wr_addr,
  input  logic [NSRC-1:0]       wr_data,
  output logic [NSRC-1:0]       en_q,
  output logic [NSRC-1:0]       byp_q
);
  sic_reg_e sel;
  assign sel = sic_reg_e'(wr_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      byp_q <= '0;
    end else if (wr_en) begin
      case (sel)
        REG_EN_SET: en_q  <= en_q | wr_data;
        REG_EN_CLR: en_q  <= en_q & ~wr_data;
        REG_BYPASS: byp_q <= wr_data;
        default: ;
      endcase
    end
  end

  AST_SET_REACHES: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == REG_EN_SET) |=> ((en_q & $past(wr_data)) == $past(wr_data))); // R2
  AST_SET_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == REG_EN_SET) |=> (($past(en_q) & ~en_q) == '0)); // R2
  AST_CLR_REACHES: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == REG_EN_CLR) |=> ((en_q & $past(wr_data)) == '0)); // R3
  AST_STATUS_WR_INERT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == REG_STATUS) |=> ($stable(en_q) && $stable(byp_q))); // R9
endmodule

// File: rtl/sic_route.sv
module sic_route #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src,
  input  logic [NSRC-1:0] en,
  input  logic [NSRC-1:0] byp,
  output logic            cascade_q,
  output logic [NSRC-1:0] direct_q
);
  logic [NSRC-1:0] merge_part;
  logic [NSRC-1:0] direct_nxt;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic pend;
    assign pend          = src[i] & en[i];
    assign merge_part[i] = pend & ~byp[i];
    assign direct_nxt[i] = pend & byp[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cascade_q <= 1'b0;
      direct_q  <= '0;
    end else begin
      cascade_q <= |merge_part;
      direct_q  <= direct_nxt;
    end
  end

  AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!cascade_q && direct_q == '0)); // R1
  AST_CASC_NEEDS_SRC: assert property (@(posedge clk) disable iff (rst)
    ((src & en & ~byp) == '0) |=> !cascade_q); // R5
  AST_DIRECT_GATED: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((direct_q & ~($past(en) & $past(byp))) == '0)); // R6
  AST_LEVEL_DROP: assert property (@(posedge clk) disable iff (rst)
    ((src & en) == '0) |=> (direct_q == '0)); // R10
endmodule

// File: rtl/sic_rd_port.sv
module sic_rd_port
  import sic_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_en,
  input  logic [SIC_ADDR_W-1:0] rd_addr,
  input  logic [NSRC-1:0]       status,
  input  logic [NSRC-1:0]       en,
  input  logic [NSRC-1:0]       byp,
  output logic [NSRC-1:0]       rd_q
);
  logic [NSRC-1:0] rd_nxt;

  always_comb begin
    case (sic_reg_e'(rd_addr))
      REG_STATUS: rd_nxt = status;
      REG_BYPASS: rd_nxt = byp;
      default:    rd_nxt = en;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= rd_nxt;
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_q)); // R4
endmodule

// File: rtl/sic_cascade_ctrl.sv
module sic_cascade_ctrl
  import sic_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NSRC-1:0]       src_irq,
  input  logic [SIC_ADDR_W-1:0] bus_addr,
  input  logic                  bus_wr,
  input  logic [NSRC-1:0]       bus_wdata,
  input  logic                  bus_rd,
  output logic [NSRC-1:0]       bus_rdata,
  output logic                  cascade_irq,
  output logic [NSRC-1:0]       bypass_irq
);
  logic [NSRC-1:0] en_mask;
  logic [NSRC-1:0] byp_mask;
  logic [NSRC-1:0] live_status;

  assign live_status = src_irq & en_mask;

  sic_mask_regs #(.NSRC(NSRC)) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .wr_addr(bus_addr),
    .wr_data(bus_wdata), .en_q(en_mask), .byp_q(byp_mask)
  );

  sic_route #(.NSRC(NSRC)) u_route (
    .clk(clk), .rst(rst), .src(src_irq), .en(en_mask), .byp(byp_mask),
    .cascade_q(cascade_irq), .direct_q(bypass_irq)
  );

  sic_rd_port #(.NSRC(NSRC)) u_rd (
    .clk(clk), .rst(rst), .rd_en(bus_rd), .rd_addr(bus_addr),
    .status(live_status), .en(en_mask), .byp(byp_mask), .rd_q(bus_rdata)
  );
endmodule

// File: tb/sic_cascade_ctrl_tb.sv
module sic_cascade_ctrl_tb;
  localparam int N = 32;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] src_irq = '0;
  logic [1:0]   bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic [N-1:0] bus_wdata = '0;
  logic         bus_rd = 1'b0;
  logic [N-1:0] bus_rdata;
  logic         cascade_irq;
  logic [N-1:0] bypass_irq;

  int n_run = 0;
  int n_fail = 0;
  logic [N-1:0] rv;

  always #5 clk = ~clk;

  sic_cascade_ctrl #(.NSRC(N)) u_dut (
    .clk(clk), .rst(rst), .src_irq(src_irq), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .cascade_irq(cascade_irq), .bypass_irq(bypass_irq)
  );

  // columns: src, enable, bypass, expected status, expected cascade, expected direct
  localparam logic [191:0] VEC [6] = '{
    {32'hFFFFFFFF, 32'h0000000F, 32'h00000000, 32'h0000000F, 32'h1, 32'h00000000},
    {32'h0000FFFF, 32'hFFFF0000, 32'h00000000, 32'h00000000, 32'h0, 32'h00000000},
    {32'hFFD00000, 32'hFFFFFFFF, 32'hFFD00000, 32'hFFD00000, 32'h0, 32'hFFD00000},
    {32'h80100001, 32'hFFFFFFFF, 32'hFFD00000, 32'h80100001, 32'h1, 32'h80100000},
    {32'h00200000, 32'h00200000, 32'hFFD00000, 32'h00200000, 32'h1, 32'h00000000},
    {32'h00500000, 32'h00100000, 32'hFFD00000, 32'h00100000, 32'h0, 32'h00100000}
  };

  task automatic chk(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    src_irq = '1;
    @(negedge clk);
    // R1 reset state
    chk(cascade_irq == 1'b0, "R1 cascade", {31'b0, cascade_irq}, 0);
    chk(bypass_irq == '0, "R1 direct", bypass_irq, 0);
    rd(2'd0, rv); chk(rv == '0, "R1 status", rv, 0);
    rd(2'd3, rv); chk(rv == '0, "R1 bypass", rv, 0);

    // table walk: R4 R5 R6
    foreach (VEC[k]) begin
      src_irq = '0;
      wr(2'd2, '1);
      wr(2'd1, VEC[k][159:128]);
      wr(2'd3, VEC[k][127:96]);
      src_irq = VEC[k][191:160];
      @(negedge clk);
      chk(cascade_irq == VEC[k][32], "R5 cascade", {31'b0, cascade_irq}, VEC[k][63:32]);
      chk(bypass_irq == VEC[k][31:0], "R6 direct", bypass_irq, VEC[k][31:0]);
      rd(2'd0, rv); chk(rv == VEC[k][95:64], "R4 status", rv, VEC[k][95:64]);
    end

    // R2 set ORs in; R7 readback on set/clear addresses
    wr(2'd2, '1);
    wr(2'd1, 32'h0000_00F0);
    wr(2'd1, 32'h0F00_0000);
    rd(2'd1, rv); chk(rv == 32'h0F00_00F0, "R2 set", rv, 32'h0F00_00F0);
    // R3 partial clear
    wr(2'd2, 32'h0100_0030);
    rd(2'd2, rv); chk(rv == 32'h0E00_00C0, "R3 clear", rv, 32'h0E00_00C0);
    rd(2'd1, rv); chk(rv == 32'h0E00_00C0, "R7 read set addr", rv, 32'h0E00_00C0);
    // R8 bypass readback
    wr(2'd3, 32'hA5A5_0000);
    rd(2'd3, rv); chk(rv == 32'hA5A5_0000, "R8 bypass", rv, 32'hA5A5_0000);
    wr(2'd3, 32'h0000_0000);
    // R9 write to status address is inert
    src_irq = 32'h0000_0040;
    wr(2'd0, '1);
    rd(2'd1, rv); chk(rv == 32'h0E00_00C0, "R9 mask kept", rv, 32'h0E00_00C0);
    rd(2'd3, rv); chk(rv == '0, "R9 bypass kept", rv, 0);
    chk(cascade_irq == 1'b1, "R9 cascade", {31'b0, cascade_irq}, 1);
    // R10 level drop and immediate masking
    src_irq = '0;
    @(negedge clk);
    chk(cascade_irq == 1'b0, "R10 drop", {31'b0, cascade_irq}, 0);
    src_irq = 32'h0000_0040;
    @(negedge clk);
    wr(2'd2, 32'h0000_0040);
    rd(2'd0, rv); chk(rv == '0, "R10 mask status", rv, 0);
    chk(cascade_irq == 1'b0, "R10 mask cascade", {31'b0, cascade_irq}, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule